// File: doc/BRIEF.md
# Burst-Grouping DMA Bus Arbiter

This block shares one memory bus toward external SDRAM among several DMA channels. Each channel raises a request. The request carries a transfer direction (read from or write to external memory) and an urgent flag. The arbiter gives the bus to one channel at a time. It keeps that grant for a burst whose length is set per channel, so words move in groups and the bus reverses direction less often.

While the granted channel keeps its request high, one word moves on every clock. The burst closes when its word count runs out, and a one-cycle done pulse marks the final word. The burst also closes at once if the channel drops its request. Either way, the arbiter then spends one cycle choosing the next owner.

The winner is chosen in this order:
- An urgent request comes first.
- Next, the lowest priority value wins.
- Channels that tie rotate round-robin, starting just after the last owner.

A new urgent request never interrupts a burst that is already running. It wins at the next boundary.

The control is a two-state machine:
- `S_ARB`: no grant is driven. The winner is chosen, and its burst length and direction are captured. The transition `ARB_TO_BURST` is taken when any request is present. With no request the state stays in `S_ARB`.
- `S_BURST`: the grant is driven. The transition `BURST_TO_ARB` is taken on the final word of the burst, or when the owner drops its request. Otherwise the state stays in `S_BURST`.

Top module: `dma_burst_arb`

## Requirements
- R1: While reset is held and in the first cycle after it, `gnt`, `beat` and `done` are all zero.
- R2: `gnt` is one-hot or zero. A grant only starts for a channel that requested in the cycle before.
- R3: `beat` is high exactly when a channel is granted and that channel's `req` is high. `gnt_wr` is the granted channel's `req_wr`, captured in the arbitration cycle and held for the whole burst.
- R4: Each channel's burst length is the 4-bit field `burst_len[4*i+3:4*i]`. A value of 1 to 15 allows that many words per grant, and 0 allows 16 words.
- R5: Once granted, the owner keeps the bus until its burst ends. No other request changes the grant, urgent requests included.
- R6: Among non-urgent requesters, the lowest 2-bit value in `prio[2*i+1:2*i]` wins, and 0 is the highest priority.
- R7: Any urgent requester (`req_urg[i]`=1) beats every non-urgent requester at the next arbitration. Among urgent requesters, R6 and R8 decide.
- R8: Among requesters with equal urgency and priority, the search starts at the channel after the last granted one and wraps. After reset the search starts at channel 0.
- R9: If the owner drops `req` during a burst, the grant is removed in the next cycle with no done pulse. The following cycle grants the next winner.
- R10: `done[i]` pulses for one cycle together with the final word of a burst that ran to its full length. It stays low otherwise.
- R11: Every burst is followed by exactly one cycle with no grant, the arbitration cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NCH | Per-channel transfer request |
| req_wr | input | NCH | Per-channel direction, 1 = write to external memory |
| req_urg | input | NCH | Per-channel urgent flag |
| burst_len | input | NCH*BLW | Per-channel burst length, 0 means 2**BLW words |
| prio | input | NCH*PRW | Per-channel priority, lower value wins |
| gnt | output | NCH | One-hot bus grant |
| gnt_wr | output | 1 | Direction of the current burst |
| beat | output | 1 | A word moves this cycle |
| done | output | NCH | One-cycle pulse on the final word of a full burst |

## Verification
The hardest case to reach from the ports is an urgent request that arrives while a lower-priority burst is in flight. The bench starts a four-word burst on a priority-3 channel. After its first word, it raises both an urgent and a higher-priority normal request. It then checks that the grant holds for the remaining words, that the gap cycle follows, and that the urgent channel wins afterwards.

Round-robin order depends on history. The vector table is therefore ordered so that each grant leaves the rotation pointer where the next vector needs it.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [0:0] {
        S_ARB   = 1'b0,
        S_BURST = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
    parameter int NCH = 4,
    parameter int PRW = 2,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]     req,
    input  logic [NCH-1:0]     urg,
    input  logic [NCH*PRW-1:0] prio,
    input  logic [IW-1:0]      last_idx,
    output logic [IW-1:0]      win_idx,
    output logic               win_vld
);
    localparam int KW = PRW + 2;

    logic [KW-1:0] key [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_key
        assign key[g] = {1'b0, ~urg[g], prio[g*PRW +: PRW]};
    end

    always_comb begin
        logic [KW-1:0] best;
        best    = '1;
        win_idx = '0;
        win_vld = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            int idx;
            idx = int'(last_idx) + 1 + k;
            if (idx >= NCH) idx = idx - NCH;
            if (req[idx] && (key[idx] < best)) begin
                best    = key[idx];
                win_idx = IW'(idx);
                win_vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_arb_beat_ctr.sv
module dma_arb_beat_ctr #(
    parameter int BLW = 4,
    localparam int CW = BLW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [BLW-1:0] len,
    input  logic           dec,
    output logic           last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            if (len == '0) cnt_q <= {1'b1, {BLW{1'b0}}};
            else           cnt_q <= {1'b0, len};
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_burst_arb.sv
module dma_burst_arb
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int BLW = 4,
    parameter int PRW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     req,
    input  logic [NCH-1:0]     req_wr,
    input  logic [NCH-1:0]     req_urg,
    input  logic [NCH*BLW-1:0] burst_len,
    input  logic [NCH*PRW-1:0] prio,
    output logic [NCH-1:0]     gnt,
    output logic               gnt_wr,
    output logic               beat,
    output logic [NCH-1:0]     done
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    arb_state_e     state_q, state_d;
    logic [IW-1:0]  owner_q, owner_d;
    logic           wr_q, wr_d;
    logic [IW-1:0]  win_idx;
    logic           win_vld;
    logic           own_req;
    logic           ctr_load, ctr_dec, ctr_last;
    logic [BLW-1:0] win_len;

    dma_arb_pick #(.NCH(NCH), .PRW(PRW)) pick_i (
        .req      (req),
        .urg      (req_urg),
        .prio     (prio),
        .last_idx (owner_q),
        .win_idx  (win_idx),
        .win_vld  (win_vld)
    );

    assign win_len = burst_len[win_idx*BLW +: BLW];
    assign own_req = req[owner_q];

    dma_arb_beat_ctr #(.BLW(BLW)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctr_load),
        .len   (win_len),
        .dec   (ctr_dec),
        .last  (ctr_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_ARB;
            owner_q <= IW'(NCH - 1);
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            wr_q    <= wr_d;
        end
    end

    // transitions: ARB_TO_BURST, BURST_TO_ARB
    always_comb begin
        state_d  = state_q;
        owner_d  = owner_q;
        wr_d     = wr_q;
        ctr_load = 1'b0;
        unique case (state_q)
            S_ARB: begin
                if (win_vld) begin
                    state_d  = S_BURST;
                    owner_d  = win_idx;
                    wr_d     = req_wr[win_idx];
                    ctr_load = 1'b1;
                end
            end
            S_BURST: begin
                if (!own_req || ctr_last) state_d = S_ARB;
            end
        endcase
    end

    assign ctr_dec = (state_q == S_BURST) && own_req;

    // outputs
    always_comb begin
        gnt    = '0;
        done   = '0;
        beat   = 1'b0;
        gnt_wr = 1'b0;
        unique case (state_q)
            S_ARB: ;
            S_BURST: begin
                gnt[owner_q] = 1'b1;
                gnt_wr       = wr_q;
                beat         = own_req;
                done[owner_q] = own_req && ctr_last;
            end
        endcase
    end
endmodule

// File: rtl/dma_burst_arb_chk.sv
module dma_burst_arb_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] req,
    input logic [NCH-1:0] gnt,
    input logic           beat,
    input logic [NCH-1:0] done
);
    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2

    AST_GNT_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (|gnt) && ($past(gnt) == '0)) |-> (|(gnt & $past(req)))); // R2

    AST_BEAT_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> (|(gnt & req))); // R3

    AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(gnt & req)) && (done == '0)) |=> (gnt == $past(gnt))); // R5

    AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ((|gnt) && !(|(gnt & req))) |=> (gnt == '0)); // R9

    AST_DONE_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> (beat && (done == gnt))); // R10

    AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> (gnt == '0)); // R11
endmodule

bind dma_burst_arb dma_burst_arb_chk #(.NCH(NCH)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt),
    .beat  (beat),
    .done  (done)
);

// File: tb/dma_burst_arb_tb_top.sv
module dma_burst_arb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NCH-1:0]  req, req_wr, req_urg;
    logic [15:0]     burst_len;
    logic [7:0]      prio;
    logic [NCH-1:0]  gnt, done;
    logic            gnt_wr, beat;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // {req, urg, prio, expected gnt}; burst length 1 on every channel
    localparam logic [19:0] VEC [0:11] = '{
        20'hF0001, 20'hF0002, 20'hF0004, 20'hF0008,
        20'hF0001, 20'hF09F4, 20'hA0008, 20'h31031,
        20'h66184, 20'h90558, 20'h90551, 20'h00000
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_burst_arb dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_urg(req_urg), .burst_len(burst_len), .prio(prio),
        .gnt(gnt), .gnt_wr(gnt_wr), .beat(beat), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        rst_n = 1'b0; req = '0; req_wr = '0; req_urg = '0;
        burst_len = 16'h1111; prio = '0;
        repeat (3) @(negedge clk);
        chk(gnt == 0 && done == 0 && beat == 0, "R1 in reset", {gnt, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(gnt == 0 && done == 0 && beat == 0, "R1 after reset", {gnt, done}, 0);

        // arbitration vectors
        for (int v = 0; v < 12; v++) begin
            @(negedge clk);
            req = VEC[v][19:16]; req_urg = VEC[v][15:12]; prio = VEC[v][11:4];
            @(negedge clk);
            chk(gnt == VEC[v][3:0], $sformatf("R6/R7/R8 vector %0d gnt", v), gnt, VEC[v][3:0]);
            chk(done == VEC[v][3:0], $sformatf("R10 vector %0d done", v), done, VEC[v][3:0]);
            req = '0; req_urg = '0;
        end
        repeat (2) @(negedge clk);

        // R4 R10 R11 R3: length 3, direction captured at grant
        prio = '0; burst_len = 16'h1131; req_wr = 4'b0010; req = 4'b0010;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk(gnt == 4'b0010 && beat, $sformatf("R4 beat %0d", k), {gnt, beat}, 5'b00101);
            chk(done == ((k == 3) ? 4'b0010 : 4'b0000), $sformatf("R10 beat %0d", k), done, (k == 3) ? 2 : 0);
            chk(gnt_wr == 1'b1, $sformatf("R3 gnt_wr beat %0d", k), gnt_wr, 1);
            req_wr = 4'b0000;
        end
        @(negedge clk);
        chk(gnt == 0 && beat == 0, "R11 gap after burst", gnt, 0);
        req = '0;
        repeat (2) @(negedge clk);

        // R4: length field 0 means 16 words
        burst_len = 16'h1110; req = 4'b0001;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk(gnt == 4'b0001 && beat, $sformatf("R4 long beat %0d", k), gnt, 1);
            chk(done == ((k == 16) ? 4'b0001 : 4'b0000), $sformatf("R10 long beat %0d", k), done, (k == 16) ? 1 : 0);
        end
        @(negedge clk);
        chk(gnt == 0, "R11 gap after 16", gnt, 0);
        req = '0;
        repeat (2) @(negedge clk);

        // R5 R7: no preemption, urgent wins at the boundary
        burst_len = 16'h1411; prio = 8'h38; req = 4'b0100;
        @(negedge clk);
        chk(gnt == 4'b0100, "R5 first beat", gnt, 4);
        req = 4'b0111; req_urg = 4'b0010;
        for (int k = 2; k <= 4; k++) begin
            @(negedge clk);
            chk(gnt == 4'b0100 && beat, $sformatf("R5 held beat %0d", k), gnt, 4);
        end
        @(negedge clk);
        chk(gnt == 0, "R11 gap before urgent", gnt, 0);
        req = 4'b0011;
        @(negedge clk);
        chk(gnt == 4'b0010, "R7 urgent after boundary", gnt, 2);
        req = '0; req_urg = '0;
        repeat (2) @(negedge clk);

        // R9: early drop
        burst_len = 16'h8111; prio = '0; req = 4'b1000;
        for (int k = 1; k <= 2; k++) begin
            @(negedge clk);
            chk(gnt == 4'b1000 && done == 0, $sformatf("R9 beat %0d", k), gnt, 8);
        end
        req = 4'b0001;
        @(negedge clk);
        chk(gnt == 0 && done == 0 && beat == 0, "R9 release", {gnt, done}, 0);
        @(negedge clk);
        chk(gnt == 4'b0001, "R9 next winner", gnt, 1);
        req = '0;
        repeat (3) @(negedge clk);
        summary();
    end
endmodule